// File: doc/BRIEF.md
# Bias DAC Serial Frame Writer

This block loads a new setting into an external bias-voltage DAC that listens on a two-wire, write-only serial bus. It never touches the bus pins. Instead it produces a sequence of 8-bit register-write words for a downstream serial link. Each word writes one control register, and two data bits of that register act as the bus clock and data lines. The start, data, acknowledge and stop phases of a bus frame are therefore built entirely from whole-register writes. Every write also carries three constant bits taken from a base pattern that the caller supplies.

The caller pulses `start_i` while the block is idle, and presents a 5-bit base pattern and the 8-bit DAC value at the same time. The block then offers 87 words, one at a time, on a valid/ready handshake. After each accepted word it waits a programmable number of cycles before it offers the next one, which enforces the minimum spacing between register writes. One cycle after the last word is accepted, a single-cycle `done_o` pulse marks the end of the frame.

The control state machine has four states:
- `ST_IDLE`: waiting for a start.
- `ST_SEND`: a word is offered.
- `ST_GAP`: the spacing delay is running.
- `ST_DONE`: the completion pulse.

Its transitions are:
- IDLE→SEND on a start strobe.
- SEND→GAP on acceptance of a word that is not the last, when the delay is non-zero.
- SEND→SEND on acceptance of a word that is not the last, when the delay is zero.
- GAP→SEND when the delay expires.
- SEND→DONE on acceptance of the last word.
- DONE→IDLE unconditionally.

A separate frame sequencer walks through the following phases: opening condition, byte bits, acknowledge slot, closing condition.

Top module: `dacw_bias_writer`

## Requirements
- R1: Every word offered has bits 7:5 equal to 3 (the register address), bits 4:2 equal to base bits 4:2 latched at start, bit 1 as the bus data line and bit 0 as the bus clock line.
- R2: A frame opens with three writes whose (clock, data) pairs are (1,1), (1,0), (0,0).
- R3: Each data bit takes three writes with the clock going 0, 1, 0 and the data line held at the bit value. Bytes are sent most significant bit first.
- R4: A frame is exactly 87 writes in this order: opening, byte 0x9C, ack slot, byte 0x00, ack slot, the DAC value byte, ack slot, closing.
- R5: Each ack slot is three writes with the clock going 0, 1, 0 and the data line low. Nothing is sampled.
- R6: A frame closes with three writes whose (clock, data) pairs are (0,0), (1,0), (1,1).
- R7: After a word is accepted, the next word is offered no sooner than GAP_CYCLES cycles later. With ready held high, accepts are exactly GAP_CYCLES+1 cycles apart.
- R8: While `word_valid_o` is high and `word_ready_i` is low, the valid signal and the word hold steady.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last word is accepted. In the cycle after that, `busy_o` is low.
- R10: A start strobe that arrives while `busy_o` is high has no effect. The frame in progress keeps its original base and value.
- R11: During and right after reset, `word_valid_o`, `busy_o` and `done_o` are low.
- R12: Base bits 1:0 do not affect any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| base_i | input | 5 | Base pattern. Bits 4:2 go into every word |
| value_i | input | 8 | DAC value byte for the frame |
| word_ready_i | input | 1 | Downstream accepts the word |
| word_valid_o | output | 1 | Word offered |
| word_o | output | 8 | Register-write word {addr, data} |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle frame completion pulse |

## Verification
Each frame is compared word for word against an expected sequence that the bench computes arithmetically from the write index. The DAC values tried are all-zero, all-one, alternating patterns, and single set bits at each end. Together these separate bit-order errors, a stuck data line, and a swap between the fixed bytes and the value byte. The base patterns differ in their low bits, which shows whether those bits leak into the words. Frames run both with ready held high and with ready stalled on a repeating pattern. The first case checks the exact spacing between accepts, and the second checks that a word is held while the downstream stalls. One frame receives a conflicting start in the middle, which shows whether such a strobe is dropped.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

    localparam int WORD_W     = 8;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = WORD_W - ADDR_W;
    localparam int BASE_KEEP  = DATA_W - 2;
    localparam int FRAME_LEN  = 87;
    localparam int STEP_W     = $clog2(FRAME_LEN + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_GAP,
        ST_DONE
    } ctrl_state_t;

    typedef enum logic [1:0] {
        PH_OPEN,
        PH_BIT,
        PH_ACK,
        PH_CLOSE
    } frame_phase_t;

    localparam logic [7:0] FIRST_BYTE  = 8'h9C;
    localparam logic [7:0] SECOND_BYTE = 8'h00;

endpackage

// File: rtl/dacw_frame_seq.sv
module dacw_frame_seq
    import dacw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       advance_i,
    input  logic [7:0] value_i,
    output logic       scl_o,
    output logic       sda_o,
    output logic       last_o
);

    frame_phase_t phase_q;
    logic [1:0]   sub_q;
    logic [1:0]   byte_q;
    logic [2:0]   bit_q;
    logic [7:0]   value_q;
    logic [7:0]   cur_byte;

    always_comb begin
        unique case (byte_q)
            2'd0:    cur_byte = FIRST_BYTE;
            2'd1:    cur_byte = SECOND_BYTE;
            default: cur_byte = value_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_OPEN;
            sub_q   <= '0;
            byte_q  <= '0;
            bit_q   <= 3'd7;
            value_q <= '0;
        end else if (load_i) begin
            phase_q <= PH_OPEN;
            sub_q   <= '0;
            byte_q  <= '0;
            bit_q   <= 3'd7;
            value_q <= value_i;
        end else if (advance_i) begin
            if (sub_q != 2'd2) begin
                sub_q <= sub_q + 2'd1;
            end else begin
                sub_q <= '0;
                unique case (phase_q)
                    PH_OPEN: begin
                        phase_q <= PH_BIT;
                        bit_q   <= 3'd7;
                    end
                    PH_BIT: begin
                        if (bit_q == 3'd0) phase_q <= PH_ACK;
                        else               bit_q   <= bit_q - 3'd1;
                    end
                    PH_ACK: begin
                        if (byte_q == 2'd2) begin
                            phase_q <= PH_CLOSE;
                        end else begin
                            byte_q  <= byte_q + 2'd1;
                            bit_q   <= 3'd7;
                            phase_q <= PH_BIT;
                        end
                    end
                    PH_CLOSE: begin
                        phase_q <= PH_CLOSE;
                    end
                    default: phase_q <= PH_OPEN;
                endcase
            end
        end
    end

    always_comb begin
        scl_o = 1'b0;
        sda_o = 1'b0;
        unique case (phase_q)
            PH_OPEN: begin
                scl_o = (sub_q != 2'd2);
                sda_o = (sub_q == 2'd0);
            end
            PH_BIT: begin
                scl_o = (sub_q == 2'd1);
                sda_o = cur_byte[bit_q];
            end
            PH_ACK: begin
                scl_o = (sub_q == 2'd1);
                sda_o = 1'b0;
            end
            PH_CLOSE: begin
                scl_o = (sub_q != 2'd0);
                sda_o = (sub_q == 2'd2);
            end
            default: begin
                scl_o = 1'b0;
                sda_o = 1'b0;
            end
        endcase
    end

    assign last_o = (phase_q == PH_CLOSE) && (sub_q == 2'd2);

    // R3: the opening condition is followed by the first byte's MSB
    p_open_to_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !load_i && phase_q == PH_OPEN && sub_q == 2'd2)
        |=> (phase_q == PH_BIT && bit_q == 3'd7 && byte_q == 2'd0));

    // R5: every ack slot ends in either another byte or the closing condition
    p_ack_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !load_i && phase_q == PH_ACK && sub_q == 2'd2)
        |=> (phase_q == PH_BIT || phase_q == PH_CLOSE));

endmodule

// File: rtl/dacw_gap_timer.sv
module dacw_gap_timer #(
    parameter int GAP_CYCLES = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);

    generate
        if (GAP_CYCLES == 0) begin : g_nogap
            assign expired_o = 1'b1;
        end else begin : g_gap
            localparam int CNT_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
            localparam logic [CNT_W-1:0] RELOAD = CNT_W'(GAP_CYCLES - 1);
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)              cnt_q <= '0;
                else if (load_i)         cnt_q <= RELOAD;
                else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
            end

            assign expired_o = (cnt_q == '0);
        end
    endgenerate

endmodule

// File: rtl/dacw_word_pack.sv
module dacw_word_pack
    import dacw_pkg::*;
#(
    parameter int REG_ADDR = 3
) (
    input  logic [DATA_W-1:0] base_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic [WORD_W-1:0] word_o
);

    localparam logic [ADDR_W-1:0] ADDR = ADDR_W'(REG_ADDR);

    logic unused_low_bits;
    assign unused_low_bits = ^base_i[1:0];

    assign word_o = {ADDR, base_i[DATA_W-1:2], sda_i, scl_i};

endmodule

// File: rtl/dacw_bias_writer.sv
module dacw_bias_writer
    import dacw_pkg::*;
#(
    parameter int GAP_CYCLES = 2500,
    parameter int REG_ADDR   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [4:0] base_i,
    input  logic [7:0] value_i,
    input  logic       word_ready_i,
    output logic       word_valid_o,
    output logic [7:0] word_o,
    output logic       busy_o,
    output logic       done_o
);

    ctrl_state_t state_q, state_d;
    logic [DATA_W-1:0] base_q;
    logic accept, launch, scl, sda, last, gap_over;

    assign launch = (state_q == ST_IDLE) && start_i;
    assign accept = (state_q == ST_SEND) && word_ready_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            if (launch) base_q <= base_i;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_SEND;
            ST_SEND: begin
                if (accept) begin
                    if (last)                 state_d = ST_DONE;
                    else if (GAP_CYCLES != 0) state_d = ST_GAP;
                    else                      state_d = ST_SEND;
                end
            end
            ST_GAP:  if (gap_over) state_d = ST_SEND;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        word_valid_o = 1'b0;
        busy_o       = 1'b0;
        done_o       = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SEND: begin
                word_valid_o = 1'b1;
                busy_o       = 1'b1;
            end
            ST_GAP:  busy_o = 1'b1;
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    dacw_frame_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (launch),
        .advance_i (accept),
        .value_i   (value_i),
        .scl_o     (scl),
        .sda_o     (sda),
        .last_o    (last)
    );

    dacw_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .expired_o (gap_over)
    );

    dacw_word_pack #(.REG_ADDR(REG_ADDR)) u_pack (
        .base_i (base_q),
        .scl_i  (scl),
        .sda_i  (sda),
        .word_o (word_o)
    );

    // spacing monitor: cycles since the last accepted word, saturating
    localparam int MON_W = $clog2(GAP_CYCLES + 2) + 1;
    localparam logic [MON_W-1:0] MON_MAX = MON_W'(GAP_CYCLES + 1);
    logic [MON_W-1:0] since_acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   since_acc_q <= MON_MAX;
        else if (accept)              since_acc_q <= '0;
        else if (since_acc_q != MON_MAX) since_acc_q <= since_acc_q + 1'b1;
    end

    p_addr_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> (word_o[7:5] == 3'(REG_ADDR)));

    p_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (since_acc_q >= MON_W'(GAP_CYCLES)));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_o && !word_ready_i) |=> (word_valid_o && $stable(word_o)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(base_q));

endmodule

// File: tb/dacw_bias_writer_tb.sv
module dacw_bias_writer_tb;

    localparam int GAP = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [4:0] base_i = '0;
    logic [7:0] value_i = '0;
    logic       word_ready_i = 1'b0;
    logic       word_valid_o;
    logic [7:0] word_o;
    logic       busy_o;
    logic       done_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dacw_bias_writer #(.GAP_CYCLES(GAP), .REG_ADDR(3)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .base_i       (base_i),
        .value_i      (value_i),
        .word_ready_i (word_ready_i),
        .word_valid_o (word_valid_o),
        .word_o       (word_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected word for write index idx (R1..R6)
    function automatic logic [7:0] exp_word(input int idx, input logic [4:0] b, input logic [7:0] v);
        logic scl, sda;
        if (idx < 3) begin                      // R2 opening
            scl = (idx != 2);
            sda = (idx == 0);
        end else if (idx >= 84) begin           // R6 closing
            scl = (idx != 84);
            sda = (idx == 86);
        end else begin
            int j, grp, r, bitn;
            logic [7:0] byt;
            j    = idx - 3;
            grp  = j / 27;
            r    = j % 27;
            bitn = r / 3;
            byt  = (grp == 0) ? 8'h9C : (grp == 1) ? 8'h00 : v;
            scl  = ((r % 3) == 1);
            sda  = (bitn < 8) ? byt[7 - bitn] : 1'b0;   // R3 data / R5 ack
        end
        return {3'b011, b[4:2], sda, scl};
    endfunction

    task automatic run_frame(input logic [4:0] b, input logic [7:0] v,
                             input bit stall, input bit poke);
        int n = 0;
        int last_acc = -1;
        bit held = 1'b0;
        logic [7:0] held_word = '0;
        @(negedge clk);
        base_i  = b;
        value_i = v;
        start_i = 1'b1;
        word_ready_i = 1'b0;
        while (n < 87 && !finished) begin
            @(negedge clk);
            cyc++;
            start_i = 1'b0;
            value_i = ~v;                        // R10: inputs after start must not matter
            base_i  = ~b;
            if (n == 0 && last_acc == -1)
                check(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
            if (poke && n == 40) begin
                start_i = 1'b1;                  // R10: start while busy
                value_i = v ^ 8'hFF;
            end
            if (held) begin
                check(word_valid_o && word_o == held_word, "R8 hold", word_o, held_word);
                held = 1'b0;
            end
            word_ready_i = stall ? ((cyc % 3) != 0) : 1'b1;
            if (word_valid_o && word_ready_i) begin
                check(word_o == exp_word(n, b, v), $sformatf("R4 word %0d", n),
                      word_o, exp_word(n, b, v));
                if (last_acc >= 0) begin
                    if (stall)
                        check(cyc - last_acc >= GAP + 1, "R7 spacing", cyc - last_acc, GAP + 1);
                    else
                        check(cyc - last_acc == GAP + 1, "R7 spacing", cyc - last_acc, GAP + 1);
                end
                last_acc = cyc;
                n++;
            end else if (word_valid_o) begin
                held = 1'b1;
                held_word = word_o;
            end
        end
        @(negedge clk);
        cyc++;
        start_i = 1'b0;
        word_ready_i = 1'b0;
        check(done_o == 1'b1, "R9 done pulse", done_o, 1);
        check(word_valid_o == 1'b0, "R4 no 88th word", word_valid_o, 0);
        @(negedge clk);
        cyc++;
        check(done_o == 1'b0, "R9 done single", done_o, 0);
        check(busy_o == 1'b0, "R9 idle after", busy_o, 0);
        repeat (3) @(negedge clk);
        check(word_valid_o == 1'b0 && busy_o == 1'b0, "R10 no restart", word_valid_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(word_valid_o == 1'b0, "R11 valid in reset", word_valid_o, 0);
        check(busy_o == 1'b0, "R11 busy in reset", busy_o, 0);
        check(done_o == 1'b0, "R11 done in reset", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!word_valid_o && !busy_o && !done_o, "R11 after reset", {word_valid_o, busy_o, done_o}, 0);

        run_frame(5'b10100, 8'h00, 1'b0, 1'b0);
        run_frame(5'b01011, 8'hFF, 1'b0, 1'b0);   // R12 low base bits set
        run_frame(5'b11111, 8'hA5, 1'b1, 1'b0);
        run_frame(5'b00001, 8'h5A, 1'b0, 1'b1);
        run_frame(5'b11010, 8'h01, 1'b1, 1'b1);
        run_frame(5'b00110, 8'h80, 1'b0, 1'b0);
        run_frame(5'b10010, 8'h7E, 1'b1, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule